// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies the even-parity bit that accompanies a 32-bit multiplexed address/data bus and its 4-bit command/byte-enable lines. The bus role (initiator or target) and the phase type (address, read data, write data) come in from the transfer controller. They decide, for each phase, whether the block drives the parity line or compares it. Parity for a phase is driven, or compared, on the clock after that phase.

Data phases count only when both the initiator-ready and target-ready qualifiers are high in the same cycle. This handshake is the block's only flow control: a cycle with one side not ready is a wait state. Wait states neither drive nor check parity, and they may be repeated any number of times. When the block receives data (target of a write, or initiator of a read), a bad data phase can be reported on the data-parity-error output. Reporting depends on a command-register enable bit. Sticky status bits record address parity errors, data parity errors and errors reported by a target. They record these whether or not reporting is enabled, and each holds until its clear input is pulsed.

Top module: `pci_par_unit`

## Requirements
- R1: Whenever the block drives parity, `par_o` makes the ones count of {ad, cbe, par} even for the address/data and command/byte-enable values of the covered phase.
- R2: As initiator (`initiator_i`=1), the block drives parity (`par_oe_o`=1) in the cycle after an address phase and in the cycle after a completed write data phase (`write_i`=1).
- R3: As target, the block drives parity in the cycle after a completed read data phase. After an address phase or a write data phase it does not drive parity (`par_oe_o`=0), and it compares `par_i` instead. On phases where it drives parity, `par_i` is ignored.
- R4: A data phase counts only in a cycle where `irdy_i`, `trdy_i` are both 1 and `addr_phase_i` is 0. In a wait-state cycle the block drives no parity and checks none.
- R5: A data parity mismatch raises `perr_o` two cycles after the completed phase, but only if `perr_report_en_i` was 1 in the cycle when parity was compared. `perr_o` stays high for one cycle per bad phase, so back-to-back bad phases give back-to-back high cycles.
- R6: `perr_o` is raised only for target write and initiator read data phases, and never for an address phase.
- R7: An address parity mismatch sets `addr_err_o` two cycles after the address phase and does not raise `perr_o`.
- R8: A data parity mismatch sets `data_err_o` two cycles after the phase, whatever the value of `perr_report_en_i`. Each sticky bit holds until its clear input is 1. A new error in the same cycle as a clear wins, and the bit stays 1.
- R9: As initiator of a write, the block samples `perr_i` two cycles after each completed data phase. If it is 1 then, `tgt_err_o` is set, visible the cycle after. At any other time `perr_i` is ignored.
- R10: During and straight after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data bus value of the current cycle |
| cbe_i | input | 4 | Command/byte-enable value of the current cycle |
| addr_phase_i | input | 1 | Current cycle is an address phase |
| initiator_i | input | 1 | 1: block is initiator, 0: target |
| write_i | input | 1 | 1: write transaction, 0: read |
| irdy_i | input | 1 | Initiator ready |
| trdy_i | input | 1 | Target ready |
| par_i | input | 1 | Parity line as seen on the bus |
| perr_i | input | 1 | Data-parity-error line driven by the other agent |
| perr_report_en_i | input | 1 | Command-register enable for parity-error reporting |
| clr_addr_err_i | input | 1 | Clears `addr_err_o` |
| clr_data_err_i | input | 1 | Clears `data_err_o` |
| clr_tgt_err_i | input | 1 | Clears `tgt_err_o` |
| par_o | output | 1 | Parity value to drive |
| par_oe_o | output | 1 | Parity output enable |
| perr_o | output | 1 | Data-parity-error report (active high) |
| addr_err_o | output | 1 | Sticky address parity error |
| data_err_o | output | 1 | Sticky data parity error |
| tgt_err_o | output | 1 | Sticky error reported by a target |

## Verification
Each result has a fixed lag from the phase that causes it. `par_oe_o` and `par_o` are due one cycle after the phase. `perr_o`, `addr_err_o` and `data_err_o` are due two cycles after it. `tgt_err_o` is due three cycles after it, once `perr_i` has been sampled at the two-cycle point. The bench changes inputs only at the falling edge and samples outputs at a later falling edge, one per elapsed cycle. That way each check falls exactly in the cycle where its result is due. Back-to-back bad phases check that `perr_o` stays high for exactly two cycles and then drops.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  typedef enum logic [1:0] {
    PAR_ACT_NONE  = 2'd0,
    PAR_ACT_GEN   = 2'd1,
    PAR_ACT_CHECK = 2'd2
  } par_act_e;

  typedef struct packed {
    par_act_e act;         // what to do with the parity line next cycle
    logic     is_addr;     // covered phase is an address phase
    logic     may_report;  // data receiver: may drive the error report
    logic     watch_perr;  // initiator write: expect target report later
  } phase_cls_t;

endpackage

// File: rtl/pci_par_xor_tree.sv
module pci_par_xor_tree #(
  parameter int W      = 36,
  parameter int LEAF_W = 8
) (
  input  logic [W-1:0] din,
  output logic         par
);
  localparam int NLEAF = (W + LEAF_W - 1) / LEAF_W;
  localparam int PAD_W = NLEAF * LEAF_W;

  logic [PAD_W-1:0] padded;
  logic [NLEAF-1:0] leaf;

  always_comb begin
    padded = '0;
    padded[W-1:0] = din;
  end

  for (genvar g = 0; g < NLEAF; g++) begin : g_leaf
    assign leaf[g] = ^padded[g*LEAF_W +: LEAF_W];
  end

  assign par = ^leaf;
endmodule

// File: rtl/pci_par_phase_cls.sv
module pci_par_phase_cls
  import pci_par_pkg::*;
(
  input  logic       addr_phase,
  input  logic       initiator,
  input  logic       write,
  input  logic       irdy,
  input  logic       trdy,
  output phase_cls_t cls
);
  logic data_done;

  assign data_done = irdy && trdy && !addr_phase;

  always_comb begin
    cls = '{act: PAR_ACT_NONE, is_addr: 1'b0, may_report: 1'b0, watch_perr: 1'b0};
    if (addr_phase) begin
      cls.is_addr = 1'b1;
      cls.act     = initiator ? PAR_ACT_GEN : PAR_ACT_CHECK;
    end else if (data_done) begin
      unique case ({initiator, write})
        2'b11: begin
          cls.act        = PAR_ACT_GEN;
          cls.watch_perr = 1'b1;
        end
        2'b10: begin
          cls.act        = PAR_ACT_CHECK;
          cls.may_report = 1'b1;
        end
        2'b01: begin
          cls.act        = PAR_ACT_CHECK;
          cls.may_report = 1'b1;
        end
        default: cls.act = PAR_ACT_GEN;
      endcase
    end
  end
endmodule

// File: rtl/pci_par_check.sv
module pci_par_check
  import pci_par_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_cls_t cls,
  input  logic       exp_par,       // registered parity of covered phase
  input  logic       par_in,
  input  logic       report_en,
  input  logic       clr_addr,
  input  logic       clr_data,
  output logic       perr,
  output logic       addr_err,
  output logic       data_err
);
  logic chk_q, chk_addr_q, chk_rep_q;
  logic mismatch, bad_addr, bad_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q      <= 1'b0;
      chk_addr_q <= 1'b0;
      chk_rep_q  <= 1'b0;
    end else begin
      chk_q      <= (cls.act == PAR_ACT_CHECK);
      chk_addr_q <= cls.is_addr;
      chk_rep_q  <= cls.may_report;
    end
  end

  assign mismatch = chk_q && (par_in != exp_par);
  assign bad_addr = mismatch && chk_addr_q;
  assign bad_data = mismatch && !chk_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr     <= 1'b0;
      addr_err <= 1'b0;
      data_err <= 1'b0;
    end else begin
      perr <= bad_data && chk_rep_q && report_en;
      if (bad_addr)      addr_err <= 1'b1;
      else if (clr_addr) addr_err <= 1'b0;
      if (bad_data)      data_err <= 1'b1;
      else if (clr_data) data_err <= 1'b0;
    end
  end
endmodule

// File: rtl/pci_par_perr_watch.sv
module pci_par_perr_watch #(
  parameter int LAG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic watch,
  input  logic perr_in,
  input  logic clr,
  output logic tgt_err
);
  logic [LAG-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= 1'b0;
    else        pipe[0] <= watch;
  end

  for (genvar s = 1; s < LAG; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= 1'b0;
      else        pipe[s] <= pipe[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       tgt_err <= 1'b0;
    else if (pipe[LAG-1] && perr_in)  tgt_err <= 1'b1;
    else if (clr)                     tgt_err <= 1'b0;
  end
endmodule

// File: rtl/pci_par_unit.sv
module pci_par_unit
  import pci_par_pkg::*;
#(
  parameter int AD_W     = 32,
  parameter int BE_W     = 4,
  parameter int LEAF_W   = 8,
  parameter int PERR_LAG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_i,
  input  logic            addr_phase_i,
  input  logic            initiator_i,
  input  logic            write_i,
  input  logic            irdy_i,
  input  logic            trdy_i,
  input  logic            par_i,
  input  logic            perr_i,
  input  logic            perr_report_en_i,
  input  logic            clr_addr_err_i,
  input  logic            clr_data_err_i,
  input  logic            clr_tgt_err_i,
  output logic            par_o,
  output logic            par_oe_o,
  output logic            perr_o,
  output logic            addr_err_o,
  output logic            data_err_o,
  output logic            tgt_err_o
);
  localparam int COV_W = AD_W + BE_W;

  phase_cls_t cls;
  logic       par_now;
  logic       par_q, oe_q;

  pci_par_phase_cls u_cls (
    .addr_phase (addr_phase_i),
    .initiator  (initiator_i),
    .write      (write_i),
    .irdy       (irdy_i),
    .trdy       (trdy_i),
    .cls        (cls)
  );

  pci_par_xor_tree #(.W(COV_W), .LEAF_W(LEAF_W)) u_tree (
    .din (({cbe_i, ad_i})),
    .par (par_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      par_q <= par_now;
      oe_q  <= (cls.act == PAR_ACT_GEN);
    end
  end

  assign par_o    = par_q && oe_q;
  assign par_oe_o = oe_q;

  pci_par_check u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cls       (cls),
    .exp_par   (par_q),
    .par_in    (par_i),
    .report_en (perr_report_en_i),
    .clr_addr  (clr_addr_err_i),
    .clr_data  (clr_data_err_i),
    .perr      (perr_o),
    .addr_err  (addr_err_o),
    .data_err  (data_err_o)
  );

  pci_par_perr_watch #(.LAG(PERR_LAG)) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .watch   (cls.watch_perr),
    .perr_in (perr_i),
    .clr     (clr_tgt_err_i),
    .tgt_err (tgt_err_o)
  );
endmodule

// File: rtl/pci_par_unit_chk.sv
module pci_par_unit_chk #(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AD_W-1:0] ad_i,
  input logic [BE_W-1:0] cbe_i,
  input logic            addr_phase_i,
  input logic            initiator_i,
  input logic            write_i,
  input logic            irdy_i,
  input logic            trdy_i,
  input logic            perr_report_en_i,
  input logic            clr_data_err_i,
  input logic            par_o,
  input logic            par_oe_o,
  input logic            perr_o,
  input logic            data_err_o
);
  AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe_o |-> ((^{$past(ad_i), $past(cbe_i), par_o}) == 1'b0)); // R1

  AST_INIT_ADDR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase_i && initiator_i) |=> par_oe_o); // R2

  AST_TGT_ADDR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase_i && !initiator_i) |=> !par_oe_o); // R3

  AST_WAIT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_phase_i && !(irdy_i && trdy_i)) |=> !par_oe_o); // R4

  AST_PERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    perr_o |-> $past(perr_report_en_i)); // R5

  AST_PERR_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    perr_o |-> $past(irdy_i && trdy_i && !addr_phase_i && (initiator_i != write_i), 2)); // R6

  AST_DATA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (data_err_o && !clr_data_err_i) |=> data_err_o); // R8
endmodule

bind pci_par_unit pci_par_unit_chk #(.AD_W(AD_W), .BE_W(BE_W)) u_par_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .ad_i             (ad_i),
  .cbe_i            (cbe_i),
  .addr_phase_i     (addr_phase_i),
  .initiator_i      (initiator_i),
  .write_i          (write_i),
  .irdy_i           (irdy_i),
  .trdy_i           (trdy_i),
  .perr_report_en_i (perr_report_en_i),
  .clr_data_err_i   (clr_data_err_i),
  .par_o            (par_o),
  .par_oe_o         (par_oe_o),
  .perr_o           (perr_o),
  .data_err_o       (data_err_o)
);

// File: tb/pci_par_unit_tb.sv
module pci_par_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic addr_phase = 0, initiator = 0, write = 0, irdy = 0, trdy = 0;
  logic par_in = 0, perr_in = 0, rep_en = 0;
  logic clr_a = 0, clr_d = 0, clr_t = 0;
  logic par_o, par_oe, perr_o, addr_err, data_err, tgt_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_par_unit dut_i (
    .clk (clk), .rst_n (rst_n), .ad_i (ad), .cbe_i (cbe),
    .addr_phase_i (addr_phase), .initiator_i (initiator), .write_i (write),
    .irdy_i (irdy), .trdy_i (trdy), .par_i (par_in), .perr_i (perr_in),
    .perr_report_en_i (rep_en), .clr_addr_err_i (clr_a),
    .clr_data_err_i (clr_d), .clr_tgt_err_i (clr_t),
    .par_o (par_o), .par_oe_o (par_oe), .perr_o (perr_o),
    .addr_err_o (addr_err), .data_err_o (data_err), .tgt_err_o (tgt_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    addr_phase = 0; irdy = 0; trdy = 0; par_in = 0; perr_in = 0;
    clr_a = 0; clr_d = 0; clr_t = 0;
  endtask

  function automatic logic even_par(logic [31:0] a, logic [3:0] c);
    return ^{a, c};
  endfunction

  task automatic phase(bit is_addr, bit init, bit wr, logic [31:0] a, logic [3:0] c);
    addr_phase = is_addr; initiator = init; write = wr;
    irdy = !is_addr; trdy = !is_addr; ad = a; cbe = c;
  endtask

  task automatic t_reset();
    check("R10 par_oe", par_oe, 0);
    check("R10 perr", perr_o, 0);
    check("R10 stickies", {addr_err, data_err, tgt_err}, 0);
  endtask

  task automatic t_init_addr(logic [31:0] a, logic [3:0] c);
    tick(); phase(1, 1, 0, a, c);
    tick(); idle();
    check("R2 par_oe after addr", par_oe, 1);
    check("R1 addr parity", par_o, even_par(a, c));
  endtask

  task automatic t_init_write_wait();
    tick(); phase(0, 1, 1, 32'h0000_0007, 4'h0); trdy = 0;
    tick(); check("R4 wait no drive", par_oe, 0);
    trdy = 1;
    tick(); idle();
    check("R2 write drive", par_oe, 1);
    check("R1 write parity", par_o, 1'b1);
  endtask

  task automatic t_init_read(bit bad, bit rep);
    logic p;
    rep_en = rep;
    tick(); phase(0, 1, 0, 32'hA5A5_0F0F, 4'hC); p = even_par(ad, cbe);
    tick(); idle(); par_in = bad ? ~p : p; clr_d = 1;
    check("R3 read no drive", par_oe, 0);
    tick(); idle();
    check("R5 perr init read", perr_o, bad && rep);
    check("R8 data sticky set-wins", data_err, bad);
    tick();
    check("R5 perr one cycle", perr_o, 0);
    clr_d = 1; tick(); clr_d = 0;
    check("R8 data sticky clear", data_err, 0);
  endtask

  task automatic t_tgt_write_norep();
    logic p;
    rep_en = 0;
    tick(); phase(0, 0, 1, 32'h1234_5678, 4'h3); p = even_par(ad, cbe);
    tick(); idle(); par_in = ~p;
    tick();
    check("R5 no perr when disabled", perr_o, 0);
    check("R8 sticky without report", data_err, 1);
    clr_d = 1; tick(); clr_d = 0;
  endtask

  task automatic t_tgt_read();
    logic p;
    rep_en = 1;
    tick(); phase(0, 0, 0, 32'hFFFF_0001, 4'h1); p = even_par(ad, cbe);
    tick(); idle(); par_in = ~p;
    check("R3 tgt read drive", par_oe, 1);
    check("R1 tgt read parity", par_o, p);
    tick();
    check("R3 par_i ignored", data_err, 0);
    check("R6 no perr on tgt read", perr_o, 0);
  endtask

  task automatic t_tgt_addr_err();
    logic p;
    rep_en = 1;
    tick(); phase(1, 0, 1, 32'h8000_0000, 4'h7); p = even_par(ad, cbe);
    tick(); idle(); par_in = ~p;
    check("R3 tgt addr no drive", par_oe, 0);
    tick();
    check("R7 addr sticky", addr_err, 1);
    check("R7 no perr for addr", perr_o, 0);
    check("R7 data sticky untouched", data_err, 0);
    clr_a = 1; tick(); clr_a = 0;
    check("R7 addr clear", addr_err, 0);
  endtask

  task automatic t_back_to_back();
    logic pa, pb;
    rep_en = 1;
    tick(); phase(0, 0, 1, 32'h0000_0001, 4'h0); pa = even_par(ad, cbe);
    tick(); phase(0, 0, 1, 32'h0000_0003, 4'h0); pb = even_par(ad, cbe); par_in = ~pa;
    tick(); idle(); par_in = ~pb;
    check("R5 perr first", perr_o, 1);
    tick(); idle();
    check("R5 perr second", perr_o, 1);
    tick();
    check("R5 perr drops", perr_o, 0);
    clr_d = 1; tick(); clr_d = 0;
  endtask

  task automatic t_tgt_report();
    tick(); phase(0, 1, 1, 32'h0F0F_0F0F, 4'hF);
    tick(); idle(); perr_in = 1;
    tick(); perr_in = 1;
    tick(); perr_in = 0;
    check("R9 target report recorded", tgt_err, 1);
    clr_t = 1; tick(); clr_t = 0;
    check("R9 clear", tgt_err, 0);
    tick(); phase(0, 0, 0, 32'h0, 4'h0);
    tick(); idle();
    tick(); perr_in = 1;
    tick(); perr_in = 0;
    check("R9 perr_i ignored outside window", tgt_err, 0);
  endtask

  initial begin
    repeat (2) tick();
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_init_addr(32'hDEAD_BEEF, 4'h6);
    t_init_addr(32'h0000_0000, 4'h1);
    t_init_write_wait();
    t_init_read(0, 1);
    t_init_read(1, 1);
    t_tgt_write_norep();
    t_tgt_read();
    t_tgt_addr_err();
    t_back_to_back();
    t_tgt_report();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule